// File: doc/BRIEF.md
# Four-Mode Serial Port with Ninth-Bit Address Filtering

This block is a full-duplex serial port for a microcontroller subsystem. Software drives it through two byte-wide locations on a simple register bus: a control/status register and a data location. A write to the data location starts a transmission. A read of the data location returns a separate receive holding register. Completed bytes land in that register and stay readable while the next frame shifts in. The register bus has no back-pressure: every write takes effect in the cycle it is presented, and reads are combinational from the addressed register.

Two mode bits pick the framing. Mode 0 is a synchronous shifter: the transmit pin carries the shift clock and the receive pin carries data in both directions. The three asynchronous modes send one start bit, eight or nine data bits least significant bit first, and one stop bit. Each asynchronous bit lasts 16 ticks of the selected rate input. In the nine-bit modes the ninth bit can mark address bytes. With the multiprocessor enable set, the receiver drops data bytes, or in the eight-bit mode it drops frames with a bad stop bit, without raising the receive flag. The transmit and receive flags are raised at mode-dependent points in the frame and are cleared only by software.

Top module: `mode_serial_port`

## Requirements
- R1: After reset the control register reads 0x00, the data location reads 0x00, `txd_o` is high, `rxd_oe` is low and both flag outputs are low.
- R2: The control register layout is: bits 7:6 mode, bit 5 multiprocessor enable, bit 4 receive enable, bit 3 transmit ninth bit, bit 2 received ninth bit, bit 1 transmit flag, bit 0 receive flag. Modes 01 and 11 use `tick_var`, and mode 10 uses `tick_fixed`, at 16 ticks per bit. A data write in modes 01–11 sends a low start bit, the data least significant bit first, and a high stop bit on `txd_o`.
- R3: In modes 10 and 11, control bit 3 is sent as a ninth data bit after bit 7.
- R4: The transmit flag (control bit 1, `tx_flag`) rises at the start of the stop bit in modes 01–11 and after the eighth shift-clock period in mode 00. It stays set until software writes a 0 to it.
- R5: In modes 01–11 with receive enable set, a received frame is written to the holding register when the stop bit is sampled at mid-bit, and the receive flag (bit 0) is set. Control bit 2 takes the ninth data bit in modes 10/11 and the stop bit in mode 01. The previous byte stays readable while a new frame shifts in.
- R6: In modes 10/11 with multiprocessor enable set, a frame whose ninth bit is 0 leaves the holding register and both flags unchanged. A frame whose ninth bit is 1 is accepted. With the enable clear, both are accepted.
- R7: In mode 01 with multiprocessor enable set, a frame with a low stop bit is discarded. With the enable clear it is accepted, and control bit 2 reads 0.
- R8: With receive enable clear, line activity changes neither the holding register nor the receive flag.
- R9: A low level on the line that is high again at mid start bit is dropped as a false start, and a following valid frame is received normally.
- R10: A frame that completes while the receive flag is still set is discarded, and the held byte is kept.
- R11: In mode 00 a data write produces eight shift-clock periods on `txd_o` (low half, then high half). `rxd_oe` is high and `rxd_o` carries the data least significant bit first, stable at each rising shift-clock edge. Both pins return to idle afterwards.
- R12: In mode 00, setting receive enable with the receive flag clear produces eight shift-clock periods. `rxd_i` is sampled at each rising edge, least significant bit first. The byte is loaded and the receive flag set after the eighth period.
- R13: A data write while an asynchronous frame is still being sent is ignored: the frame in progress is unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fixed | input | 1 | Fixed-rate tick (16x bit rate; half shift-clock period in mode 00) |
| tick_var | input | 1 | Variable-rate tick (16x bit rate) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| rxd_i | input | 1 | Receive line input |
| rxd_o | output | 1 | Mode 00 transmit data |
| rxd_oe | output | 1 | Output enable for `rxd_o` |
| txd_o | output | 1 | Asynchronous transmit line, or shift clock in mode 00 |
| tx_flag | output | 1 | Transmit flag (control bit 1) |
| rx_flag | output | 1 | Receive flag (control bit 0) |

## Verification
A wrong bit counter or tick select in the transmitter shows up within one frame as a shifted or mistimed bit on `txd_o`, or as the transmit flag rising one bit early or late. The bench decodes every bit at mid-period and samples the flag in the last data bit and in the stop bit. A bad filter decision or a wrong holding-register update is visible at the next read of the control or data location after the stop bit. The bench reads both after every frame and compares them with the byte it expects to be held. Mode 00 errors appear at the rising shift-clock edges, where the bench compares every data bit.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_DW = 8;

  typedef enum logic [1:0] {
    MD_SHIFT   = 2'b00,
    MD_ASYNC8  = 2'b01,
    MD_ASYNC9F = 2'b10,
    MD_ASYNC9V = 2'b11
  } sp_mode_e;

  localparam int CB_RXF = 0;
  localparam int CB_TXF = 1;
  localparam int CB_RX9 = 2;
  localparam int CB_TX9 = 3;
  localparam int CB_REN = 4;
  localparam int CB_MPE = 5;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/sp_shift0.sv
// Synchronous shift engine: drives the shift clock and moves one byte in
// either direction, one bit per two ticks.
module sp_shift0 #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_tx,
  input  logic          start_rx,
  input  logic [DW-1:0] din,
  input  logic          rxd,
  output logic          sclk,
  output logic          dout,
  output logic          doe,
  output logic          done,
  output logic          is_rx,
  output logic [DW-1:0] rx_data
);
  localparam int HW = $clog2(2 * DW);
  localparam logic [HW-1:0] HLAST = HW'(2 * DW - 1);

  logic          busy;
  logic          dir_rx;
  logic [HW-1:0] half;
  logic [DW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      dir_rx <= 1'b0;
      half   <= '0;
      sh     <= '0;
    end else if (!busy) begin
      if (start_tx) begin
        busy   <= 1'b1;
        dir_rx <= 1'b0;
        half   <= '0;
        sh     <= din;
      end else if (start_rx) begin
        busy   <= 1'b1;
        dir_rx <= 1'b1;
        half   <= '0;
        sh     <= '0;
      end
    end else if (tick) begin
      if (!half[0]) begin
        // clock rises: receiver samples
        if (dir_rx) sh <= {rxd, sh[DW-1:1]};
      end else if (!dir_rx) begin
        // clock falls: transmitter presents next bit
        sh <= {1'b0, sh[DW-1:1]};
      end
      if (half == HLAST) busy <= 1'b0;
      half <= half + 1'b1;
    end
  end

  assign done    = busy && tick && (half == HLAST);
  assign is_rx   = dir_rx;
  assign sclk    = busy ? half[0] : 1'b1;
  assign dout    = sh[0];
  assign doe     = busy && !dir_rx;
  assign rx_data = sh;
endmodule

// File: rtl/sp_async_tx.sv
// Asynchronous frame transmitter with a selectable ninth bit.
module sp_async_tx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          nine,
  input  logic          bit9,
  input  logic [DW-1:0] din,
  output logic          txd,
  output logic          stop_begin
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(FW);

  logic          busy;
  logic          nine_q;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [FW-1:0] sh;
  logic [IW-1:0] stop_idx;
  logic          bit_end;

  assign stop_idx = nine_q ? IW'(DW + 2) : IW'(DW + 1);
  assign bit_end  = busy && tick && (cnt == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      nine_q <= 1'b0;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '1;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        nine_q <= nine;
        cnt    <= '0;
        idx    <= '0;
        sh     <= nine ? {1'b1, bit9, din, 1'b0} : {2'b11, din, 1'b0};
      end
    end else if (tick) begin
      if (cnt == CW'(OVS - 1)) begin
        cnt <= '0;
        sh  <= {1'b1, sh[FW-1:1]};
        if (idx == stop_idx) busy <= 1'b0;
        else idx <= idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign stop_begin = bit_end && (idx == stop_idx - 1'b1);
  assign txd        = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/sp_async_rx.sv
// Asynchronous frame receiver, 16x oversampled, one sample at mid-bit.
module sp_async_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          stop_ok
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = $clog2(DW + 2);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_st_e;

  rx_st_e        st;
  logic          lvl;
  logic          nine_q;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW:0]   sh;
  logic [IW-1:0] stop_idx;

  assign stop_idx = nine_q ? IW'(DW + 1) : IW'(DW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      lvl     <= 1'b1;
      nine_q  <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      done    <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) lvl <= rxd;
      case (st)
        RX_IDLE: begin
          if (tick && en && lvl && !rxd) begin
            st     <= RX_START;
            cnt    <= '0;
            nine_q <= nine;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              idx <= '0;
              st  <= rxd ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (cnt == CW'(OVS - 1)) begin
              cnt <= '0;
              if (idx == stop_idx) begin
                st      <= RX_IDLE;
                done    <= 1'b1;
                stop_ok <= rxd;
              end else begin
                sh  <= {rxd, sh[DW:1]};
                idx <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign data = nine_q ? sh[DW-1:0] : sh[DW:1];
  assign bit9 = sh[DW];
endmodule

// File: rtl/mode_serial_port.sv
module mode_serial_port
  import sp_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_fixed,
  input  logic             tick_var,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [SP_DW-1:0] reg_wdata,
  output logic [SP_DW-1:0] reg_rdata,
  input  logic             rxd_i,
  output logic             rxd_o,
  output logic             rxd_oe,
  output logic             txd_o,
  output logic             tx_flag,
  output logic             rx_flag
);
  logic [7:0]       ctrl_q;
  logic [SP_DW-1:0] rbuf_q;
  logic [SYNC-1:0]  rx_sync;
  logic             rxd_s;

  logic     wr_ctrl, wr_data;
  sp_mode_e mode;
  logic     sync_md, nine, atick, ren, mpe, rxf;

  assign wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
  assign wr_data = reg_we && (reg_addr == ADDR_DATA);
  assign mode    = sp_mode_e'(ctrl_q[7:6]);
  assign sync_md = (mode == MD_SHIFT);
  assign nine    = (mode == MD_ASYNC9F) || (mode == MD_ASYNC9V);
  assign atick   = ((mode == MD_ASYNC8) || (mode == MD_ASYNC9V)) ? tick_var : tick_fixed;
  assign ren     = ctrl_q[CB_REN];
  assign mpe     = ctrl_q[CB_MPE];
  assign rxf     = ctrl_q[CB_RXF];

  // input synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sync <= '1;
    else        rx_sync <= {rx_sync[SYNC-2:0], rxd_i};
  end
  assign rxd_s = rx_sync[SYNC-1];

  // synchronous shift engine
  logic             s_sclk, s_dout, s_doe, s_done, s_is_rx;
  logic [SP_DW-1:0] s_data;

  sp_shift0 #(.DW(SP_DW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_fixed),
    .start_tx (wr_data && sync_md),
    .start_rx (sync_md && ren && !rxf),
    .din      (reg_wdata),
    .rxd      (rxd_s),
    .sclk     (s_sclk),
    .dout     (s_dout),
    .doe      (s_doe),
    .done     (s_done),
    .is_rx    (s_is_rx),
    .rx_data  (s_data)
  );

  // asynchronous transmitter
  logic a_txd, a_stop;

  sp_async_tx #(.OVS(OVS), .DW(SP_DW)) u_atx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (atick),
    .start      (wr_data && !sync_md),
    .nine       (nine),
    .bit9       (ctrl_q[CB_TX9]),
    .din        (reg_wdata),
    .txd        (a_txd),
    .stop_begin (a_stop)
  );

  // asynchronous receiver
  logic             r_done, r_bit9, r_stop;
  logic [SP_DW-1:0] r_data;

  sp_async_rx #(.OVS(OVS), .DW(SP_DW)) u_arx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (atick),
    .en      (!sync_md && ren),
    .nine    (nine),
    .rxd     (rxd_s),
    .done    (r_done),
    .data    (r_data),
    .bit9    (r_bit9),
    .stop_ok (r_stop)
  );

  // acceptance filter
  logic rb8_new, a_accept, s_accept;
  assign rb8_new  = nine ? r_bit9 : r_stop;
  assign a_accept = r_done && !sync_md && ren && !rxf && (!mpe || rb8_new);
  assign s_accept = s_done && s_is_rx && ren && !rxf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rbuf_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (a_stop || (s_done && !s_is_rx)) ctrl_q[CB_TXF] <= 1'b1;
      if (a_accept) begin
        ctrl_q[CB_RXF] <= 1'b1;
        ctrl_q[CB_RX9] <= rb8_new;
        rbuf_q         <= r_data;
      end
      if (s_accept) begin
        ctrl_q[CB_RXF] <= 1'b1;
        rbuf_q         <= s_data;
      end
    end
  end

  assign reg_rdata = (reg_addr == ADDR_DATA) ? rbuf_q : ctrl_q;
  assign txd_o     = sync_md ? s_sclk : a_txd;
  assign rxd_o     = s_dout;
  assign rxd_oe    = s_doe;
  assign tx_flag   = ctrl_q[CB_TXF];
  assign rx_flag   = ctrl_q[CB_RXF];
endmodule

// File: rtl/sp_checker.sv
module sp_checker
  import sp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic       reg_addr,
  input logic [7:0] ctrl_q,
  input logic [7:0] rbuf_q,
  input logic       tx_flag,
  input logic       rx_flag,
  input logic       rxd_oe
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL);

  // R4
  tx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flag && !ctrl_wr) |=> tx_flag);

  // R5
  rx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !ctrl_wr) |=> rx_flag);

  // R10
  held_byte_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |=> $stable(rbuf_q));

  // R11
  oe_only_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_oe |-> (ctrl_q[7:6] == 2'b00));

  // R8
  rx_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_flag) && !$past(ctrl_wr)) |-> $past(ctrl_q[CB_REN]));
endmodule

bind mode_serial_port sp_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .ctrl_q   (ctrl_q),
  .rbuf_q   (rbuf_q),
  .tx_flag  (tx_flag),
  .rx_flag  (rx_flag),
  .rxd_oe   (rxd_oe)
);

// File: tb/sim_mode_serial_port.sv
`timescale 1ns/1ps
module sim_mode_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_fixed;
  logic       tick_var = 1'b1;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rxd_i = 1'b1;
  logic       rxd_o, rxd_oe, txd_o, tx_flag, rx_flag;
  logic [1:0] fdiv = 2'd0;

  int nchk = 0;
  int nfail = 0;
  int held = 0;
  bit done_flag = 0;

  localparam int VB = 16;   // cycles per bit on tick_var (every cycle)
  localparam int FB = 64;   // cycles per bit on tick_fixed (every 4 cycles)

  always #5 clk = ~clk;
  always @(posedge clk) fdiv <= fdiv + 2'd1;
  assign tick_fixed = (fdiv == 2'd0);

  mode_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .tick_fixed(tick_fixed), .tick_var(tick_var),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd_i(rxd_i), .rxd_o(rxd_o), .rxd_oe(rxd_oe), .txd_o(txd_o),
    .tx_flag(tx_flag), .rx_flag(rx_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d[7:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output int d);
    @(negedge clk);
    reg_addr = a;
    #1 d = int'(reg_rdata);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // decode an asynchronous frame from txd_o at mid-bit points
  task automatic decode(input int bc, input int nd, output int val,
                        output int stopv, output int ti_last, output int ti_stop);
    val = 0;
    ti_last = 0;
    while (txd_o) @(negedge clk);
    waitc(bc / 2);
    for (int i = 0; i < nd; i++) begin
      waitc(bc);
      val = val | (int'(txd_o) << i);
      if (i == nd - 1) ti_last = int'(tx_flag);
    end
    waitc(bc);
    stopv = int'(txd_o);
    ti_stop = int'(tx_flag);
  endtask

  // drive an asynchronous frame onto rxd_i
  task automatic send(input int bc, input int nd, input int val, input bit stopv);
    @(negedge clk);
    rxd_i = 1'b0;
    waitc(bc);
    for (int i = 0; i < nd; i++) begin
      rxd_i = val[i];
      waitc(bc);
    end
    rxd_i = stopv;
    waitc(bc);
    rxd_i = 1'b1;
    waitc(4);
  endtask

  task automatic summary;
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    int v, sv, tl, ts, c, d;
    waitc(5);
    rst_n = 1'b1;
    waitc(2);

    // R1 reset state
    rd(1'b0, c); chk("R1 ctrl", c, 0);
    rd(1'b1, d); chk("R1 data", d, 0);
    chk("R1 txd", int'(txd_o), 1);
    chk("R1 oe", int'(rxd_oe), 0);
    chk("R1 flags", int'({tx_flag, rx_flag}), 0);

    // R2 R4 mode 01 transmit sweep
    wr(1'b0, 8'h40);
    for (int b = 0; b < 256; b++) begin
      wr(1'b1, b);
      decode(VB, 8, v, sv, tl, ts);
      chk("R2 mode1 data", v, b);
      chk("R2 mode1 stop", sv, 1);
      chk("R4 ti timing", tl * 2 + ts, 1);
      waitc(12);
      wr(1'b0, 8'h40);
    end

    // R3 nine-bit transmit, variable (mode 11) and fixed (mode 10) rates
    for (int k = 0; k < 8; k++) begin
      int b = (k * 37 + 90) & 255;
      int t9 = k & 1;
      wr(1'b0, 8'hC0 | (t9 << 3));
      wr(1'b1, b);
      decode(VB, 9, v, sv, tl, ts);
      chk("R3 mode3 nine-bit frame", v, b | (t9 << 8));
      chk("R4 ti mode3", tl * 2 + ts, 1);
      waitc(12);
      wr(1'b0, 8'h80 | (t9 << 3));
      wr(1'b1, b ^ 8'hFF);
      decode(FB, 9, v, sv, tl, ts);
      chk("R3 mode2 nine-bit frame", v, (b ^ 255) | (t9 << 8));
      chk("R2 mode2 stop", sv, 1);
      waitc(40);
    end

    // R13 write during transmission is ignored
    wr(1'b0, 8'h40);
    wr(1'b1, 8'hA5);
    wr(1'b1, 8'h3C);
    decode(VB, 8, v, sv, tl, ts);
    chk("R13 first frame intact", v, 8'hA5);
    c = 0;
    for (int i = 0; i < 40; i++) begin
      waitc(1);
      if (!txd_o) c++;
    end
    chk("R13 no second frame", c, 0);

    // R5 mode 01 receive sweep
    wr(1'b0, 8'h50);
    for (int b = 1; b < 256; b += 5) begin
      send(VB, 8, b, 1'b1);
      rd(1'b0, c); chk("R5 flag and stop latch", c & 5, 5);
      rd(1'b1, d); chk("R5 data", d, b);
      wr(1'b0, 8'h50);
      held = b;
    end

    // R5 buffered: held byte readable while next frame arrives
    fork
      send(VB, 8, 8'hC3, 1'b1);
      begin
        waitc(80);
        rd(1'b1, d);
        chk("R5 held during shift", d, held);
      end
    join
    rd(1'b1, d); chk("R5 new byte", d, 8'hC3);
    held = 8'hC3;
    wr(1'b0, 8'h50);

    // R10 completion with flag still set is discarded
    send(VB, 8, 8'h11, 1'b1);
    send(VB, 8, 8'h22, 1'b1);
    rd(1'b1, d); chk("R10 first byte kept", d, 8'h11);
    rd(1'b0, c); chk("R10 flag still set", c & 1, 1);
    held = 8'h11;
    wr(1'b0, 8'h50);

    // R9 false start
    @(negedge clk); rxd_i = 1'b0;
    waitc(4);
    rxd_i = 1'b1;
    waitc(40);
    rd(1'b0, c); chk("R9 false start ignored", c & 1, 0);
    send(VB, 8, 8'h3B, 1'b1);
    rd(1'b1, d); chk("R9 following frame", d, 8'h3B);
    held = 8'h3B;
    wr(1'b0, 8'h50);

    // R7 mode 01 stop-bit filter
    wr(1'b0, 8'h70);
    send(VB, 8, 8'h96, 1'b0);
    waitc(20);
    rd(1'b0, c); chk("R7 bad stop dropped flag", c & 1, 0);
    rd(1'b1, d); chk("R7 bad stop dropped data", d, held);
    send(VB, 8, 8'h69, 1'b1);
    rd(1'b1, d); chk("R7 good stop accepted", d, 8'h69);
    wr(1'b0, 8'h50);
    send(VB, 8, 8'h0F, 1'b0);
    waitc(20);
    rd(1'b0, c); chk("R7 no filter flag, rx9 low", c & 5, 1);
    rd(1'b1, d); chk("R7 no filter data", d, 8'h0F);
    held = 8'h0F;
    wr(1'b0, 8'h50);

    // R6 ninth-bit filter, mode 11 and mode 10
    wr(1'b0, 8'hF0);
    send(VB, 9, 8'h55, 1'b1);
    rd(1'b0, c); chk("R6 data byte dropped", c & 1, 0);
    rd(1'b1, d); chk("R6 data byte no load", d, held);
    send(VB, 9, 9'h1AA, 1'b1);
    rd(1'b0, c); chk("R6 address accepted rx9", c & 5, 5);
    rd(1'b1, d); chk("R6 address data", d, 8'hAA);
    wr(1'b0, 8'hB0);
    send(FB, 9, 9'h133, 1'b1);
    rd(1'b1, d); chk("R6 mode2 address", d, 8'h33);
    wr(1'b0, 8'hD0);
    send(VB, 9, 8'h77, 1'b1);
    rd(1'b0, c); chk("R6 unfiltered rx9 low", c & 5, 1);
    rd(1'b1, d); chk("R6 unfiltered data", d, 8'h77);
    held = 8'h77;

    // R8 receive disabled
    wr(1'b0, 8'h40);
    send(VB, 8, 8'hE1, 1'b1);
    rd(1'b0, c); chk("R8 flag stays clear", c & 1, 0);
    rd(1'b1, d); chk("R8 data unchanged", d, held);

    // R11 mode 00 transmit sweep
    wr(1'b0, 8'h00);
    waitc(2);
    chk("R11 idle clock", int'(txd_o), 1);
    chk("R11 idle oe", int'(rxd_oe), 0);
    for (int b = 0; b < 256; b++) begin
      v = 0; c = 1;
      wr(1'b1, b);
      for (int i = 0; i < 8; i++) begin
        @(posedge txd_o);
        #1;
        v = v | (int'(rxd_o) << i);
        if (!rxd_oe) c = 0;
      end
      chk("R4 mode0 ti not early", int'(tx_flag), 0);
      waitc(10);
      chk("R11 shift data", v, b);
      chk("R11 oe during shift", c, 1);
      chk("R4 mode0 ti after eighth", int'(tx_flag), 1);
      chk("R11 back to idle", int'({txd_o, rxd_oe}), 2);
      wr(1'b0, 8'h00);
    end

    // R12 mode 00 receive sweep
    for (int b = 0; b < 256; b++) begin
      rxd_i = b[0];
      wr(1'b0, 8'h10);
      for (int i = 0; i < 8; i++) begin
        @(posedge txd_o);
        #1;
        if (i < 7) rxd_i = b[i+1];
      end
      waitc(10);
      rd(1'b0, c); chk("R12 flag set", c & 1, 1);
      rd(1'b1, d); chk("R12 data", d, b);
      wr(1'b0, 8'h00);
    end
    rxd_i = 1'b1;

    waitc(5);
    summary();
  end
endmodule